// File: doc/BRIEF.md
# Restricted Burst Profile Monitor

This block watches the read-address and write-address channels of a cache-coherent processor's AXI3-style master port, without driving them. It looks only at requests that complete their address handshake. For each one it judges whether the request belongs to the small set of shapes that such a processor emits:

- wrapping full-line fills;
- short incrementing bursts of wide beats that stay within one line;
- single-beat accesses of any size up to the wide beat, including exclusive ones.

Anything outside that set is reported one cycle later as a single-cycle error pulse with a 3-bit reason. Each channel also has two saturating counters: one for checked requests and one for violations. The monitor reports each checked request's address, cache attributes and privilege bit alongside the verdict. It is meant to sit beside the port in simulation or silicon debug and expose masters or fabrics that misbehave.

The read and write channels have identical, independent checking paths. Either path may accept a request in any cycle, and both may do so in the same cycle. Reason codes are:

| Code | Meaning |
|------|---------|
| 0 | none |
| 1 | fixed burst |
| 2 | illegal shape |
| 3 | line crossing |
| 4 | exclusive misuse |
| 5 | misaligned |

Top module: `axi_subset_monitor`

## Requirements
- R1: A request is sampled only in a cycle where valid and ready are both high. In the following cycle `*_chk` is high for exactly one cycle, and `*_code`, `*_addr`, `*_cache` and `*_priv` show that request. Without a handshake there is no pulse and the counters hold.
- R2: Burst type 2'b00 (fixed) gives reason 1 on either channel. Burst type 2'b11 is reserved and gives reason 2.
- R3: A wrapping burst (burst 2'b10) is legal only with size code 4 (16 bytes) and length field 3 (4 beats). It may start at any 16-byte word of the 64-byte line. Any other size or length gives reason 2.
- R4: An incrementing burst (burst 2'b01) with length field 0 is legal for size codes 0 to 4. Size codes 5 to 7 give reason 2. With more than one beat it is legal only at size code 4 with 2 or 4 beats; otherwise it gives reason 2.
- R5: An incrementing burst whose start offset within its 64-byte line plus its total byte count exceeds 64 gives reason 3.
- R6: With the exclusive flag set, a request is legal only if it is a single-beat incrementing access. Any other exclusive request gives reason 4.
- R7: A start address that is not a multiple of the beat size (2^size bytes) gives reason 5.
- R8: When several rules fail together, the reported reason is the lowest non-zero code: 1, then 2, then 3, then 4, then 5.
- R9: The privilege bit and the cache attributes are captured with each checked request. They never change the verdict.
- R10: The checked-request and violation counters saturate at 2^CNT_W-1. The violation count never exceeds the checked count.
- R11: A synchronous active-high reset clears both counters and all pulses of both channels.
- R12: Requests accepted on the read and write channels in the same cycle are judged and counted independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ar_valid | input | 1 | read address valid |
| ar_ready | input | 1 | read address ready |
| ar_addr | input | ADDR_W | read start address |
| ar_len | input | LEN_W | read beats minus one |
| ar_size | input | 3 | read beat size code (bytes = 2^size) |
| ar_burst | input | 2 | read burst type |
| ar_lock | input | 1 | read exclusive flag |
| ar_cache | input | 4 | read cache attributes |
| ar_priv | input | 1 | read privilege bit (bit 0 of protection) |
| aw_valid | input | 1 | write address valid |
| aw_ready | input | 1 | write address ready |
| aw_addr | input | ADDR_W | write start address |
| aw_len | input | LEN_W | write beats minus one |
| aw_size | input | 3 | write beat size code |
| aw_burst | input | 2 | write burst type |
| aw_lock | input | 1 | write exclusive flag |
| aw_cache | input | 4 | write cache attributes |
| aw_priv | input | 1 | write privilege bit |
| rd_chk | output | 1 | pulse: a read request was checked |
| rd_err | output | 1 | pulse: the checked read request violated a rule |
| rd_code | output | 3 | reason of the last checked read request |
| rd_addr | output | ADDR_W | address of the last checked read request |
| rd_cache | output | 4 | cache attributes of the last checked read request |
| rd_priv | output | 1 | privilege bit of the last checked read request |
| rd_chk_cnt | output | CNT_W | saturating count of checked read requests |
| rd_err_cnt | output | CNT_W | saturating count of violating read requests |
| wr_chk | output | 1 | pulse: a write request was checked |
| wr_err | output | 1 | pulse: the checked write request violated a rule |
| wr_code | output | 3 | reason of the last checked write request |
| wr_addr | output | ADDR_W | address of the last checked write request |
| wr_cache | output | 4 | cache attributes of the last checked write request |
| wr_priv | output | 1 | privilege bit of the last checked write request |
| wr_chk_cnt | output | CNT_W | saturating count of checked write requests |
| wr_err_cnt | output | CNT_W | saturating count of violating write requests |

## Verification
Two things can land in the same cycle.

- **Handshakes on both channels.** The bench drives both address channels with handshakes in one cycle, carrying different violations, so each channel must produce its own pulse, reason and counter step. It also runs back-to-back handshakes on one channel.
- **Several rules failing in one request.** Requests are built to break several rules at once, for example a fixed burst that is also exclusive and misaligned, or a line-crossing access that is also misaligned. Only the highest-priority reason may appear.

Every cycle is compared against a behavioural model in the bench that derives the expected reason and counts from the requirements alone.

// File: rtl/axsm_pkg.sv
package axsm_pkg;

   typedef enum logic [2:0] {
      RSN_NONE  = 3'd0,
      RSN_FIXED = 3'd1,
      RSN_SHAPE = 3'd2,
      RSN_CROSS = 3'd3,
      RSN_EXCL  = 3'd4,
      RSN_ALIGN = 3'd5
   } reason_e;

   localparam logic [1:0] BT_FIXED = 2'b00;
   localparam logic [1:0] BT_INCR  = 2'b01;
   localparam logic [1:0] BT_WRAP  = 2'b10;

endpackage

// File: rtl/axsm_rule_eval.sv
module axsm_rule_eval
   import axsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int LINE_BYTES = 64,
   parameter int WIDE_SIZE  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic [2:0]        size,
   input  logic [1:0]        burst,
   input  logic              lock,
   output reason_e           reason
);

   localparam int LINE_LOG2  = $clog2(LINE_BYTES);
   localparam int WIDE_BEATS = LINE_BYTES >> WIDE_SIZE;
   localparam int BEATS_W    = LEN_W + 1;
   localparam int TOT_W      = LEN_W + 8;

   logic [BEATS_W-1:0] beats;
   logic [TOT_W-1:0]   bytes_tot;
   logic [TOT_W-1:0]   end_off;
   logic               single;
   logic               wide;
   logic               pow2_beats;
   logic               shape_bad;
   logic               cross_bad;
   logic               excl_bad;
   logic [7:0]         low_bad;
   logic               align_bad;

   assign beats      = {1'b0, len} + {{LEN_W{1'b0}}, 1'b1};
   assign single     = (len == '0);
   assign wide       = (size == 3'(WIDE_SIZE));
   assign pow2_beats = ((beats & {1'b0, len}) == '0);
   assign bytes_tot  = TOT_W'(beats) << size;
   assign end_off    = TOT_W'(addr[LINE_LOG2-1:0]) + bytes_tot;

   // shape rules per burst type
   always_comb begin
      unique case (burst)
         BT_FIXED: shape_bad = 1'b0;
         BT_INCR:  shape_bad = single ? (size > 3'(WIDE_SIZE))
                                      : !(wide && pow2_beats &&
                                          (beats <= BEATS_W'(WIDE_BEATS)));
         BT_WRAP:  shape_bad = !(wide && (beats == BEATS_W'(WIDE_BEATS)));
         default:  shape_bad = 1'b1;
      endcase
   end

   assign cross_bad = (burst == BT_INCR) && (end_off > TOT_W'(LINE_BYTES));
   assign excl_bad  = lock && !((burst == BT_INCR) && single);

   // one comparator per possible low address bit
   for (genvar b = 0; b < 8; b++) begin : g_align
      assign low_bad[b] = addr[b] & (3'(b) < size);
   end
   assign align_bad = |low_bad;

   always_comb begin
      if (burst == BT_FIXED)  reason = RSN_FIXED;
      else if (shape_bad)     reason = RSN_SHAPE;
      else if (cross_bad)     reason = RSN_CROSS;
      else if (excl_bad)      reason = RSN_EXCL;
      else if (align_bad)     reason = RSN_ALIGN;
      else                    reason = RSN_NONE;
   end

endmodule

// File: rtl/axsm_sat_cnt.sv
module axsm_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                      cnt_q <= '0;
      else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (rst)
      cnt_q == TOP |=> cnt_q == TOP);                                   // R10
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      inc && cnt_q != TOP |=> cnt_q == $past(cnt_q) + 1'b1);            // R10

endmodule

// File: rtl/axsm_channel.sv
module axsm_channel
   import axsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int LINE_BYTES = 64,
   parameter int WIDE_SIZE  = 4,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic              ready,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic [2:0]        size,
   input  logic [1:0]        burst,
   input  logic              lock,
   input  logic [3:0]        cache,
   input  logic              priv,
   output logic              chk,
   output logic              err,
   output logic [2:0]        code,
   output logic [ADDR_W-1:0] o_addr,
   output logic [3:0]        o_cache,
   output logic              o_priv,
   output logic [CNT_W-1:0]  chk_cnt,
   output logic [CNT_W-1:0]  err_cnt
);

   logic              hs;
   logic              bad;
   reason_e           reason;
   logic              chk_q, err_q, priv_q;
   reason_e           code_q;
   logic [ADDR_W-1:0] addr_q;
   logic [3:0]        cache_q;

   assign hs  = valid & ready;
   assign bad = (reason != RSN_NONE);

   axsm_rule_eval #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .LINE_BYTES(LINE_BYTES), .WIDE_SIZE(WIDE_SIZE)
   ) u_eval (
      .addr(addr), .len(len), .size(size), .burst(burst),
      .lock(lock), .reason(reason)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         chk_q   <= 1'b0;
         err_q   <= 1'b0;
         code_q  <= RSN_NONE;
         addr_q  <= '0;
         cache_q <= '0;
         priv_q  <= 1'b0;
      end else begin
         chk_q <= hs;
         err_q <= hs && bad;
         if (hs) begin
            code_q  <= reason;
            addr_q  <= addr;
            cache_q <= cache;
            priv_q  <= priv;
         end
      end
   end

   axsm_sat_cnt #(.W(CNT_W)) u_chk_cnt (
      .clk(clk), .rst(rst), .inc(hs), .cnt(chk_cnt)
   );
   axsm_sat_cnt #(.W(CNT_W)) u_err_cnt (
      .clk(clk), .rst(rst), .inc(hs && bad), .cnt(err_cnt)
   );

   assign chk     = chk_q;
   assign err     = err_q;
   assign code    = code_q;
   assign o_addr  = addr_q;
   assign o_cache = cache_q;
   assign o_priv  = priv_q;

   AST_ERR_WITH_CHK: assert property (@(posedge clk) disable iff (rst)
      err_q |-> chk_q);                                                 // R1
   AST_PULSE_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
      hs |=> chk_q);                                                    // R1
   AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
      !hs |=> $stable(chk_cnt));                                        // R1
   AST_FIXED_FIRST: assert property (@(posedge clk) disable iff (rst)
      hs && burst == BT_FIXED |=> code_q == RSN_FIXED);                 // R2
   AST_ERR_LE_CHK: assert property (@(posedge clk) disable iff (rst)
      err_cnt <= chk_cnt);                                              // R10

endmodule

// File: rtl/axi_subset_monitor.sv
module axi_subset_monitor #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int LINE_BYTES = 64,
   parameter int WIDE_SIZE  = 4,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ar_valid,
   input  logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   input  logic [2:0]        ar_size,
   input  logic [1:0]        ar_burst,
   input  logic              ar_lock,
   input  logic [3:0]        ar_cache,
   input  logic              ar_priv,
   input  logic              aw_valid,
   input  logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic [2:0]        aw_size,
   input  logic [1:0]        aw_burst,
   input  logic              aw_lock,
   input  logic [3:0]        aw_cache,
   input  logic              aw_priv,
   output logic              rd_chk,
   output logic              rd_err,
   output logic [2:0]        rd_code,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [3:0]        rd_cache,
   output logic              rd_priv,
   output logic [CNT_W-1:0]  rd_chk_cnt,
   output logic [CNT_W-1:0]  rd_err_cnt,
   output logic              wr_chk,
   output logic              wr_err,
   output logic [2:0]        wr_code,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [3:0]        wr_cache,
   output logic              wr_priv,
   output logic [CNT_W-1:0]  wr_chk_cnt,
   output logic [CNT_W-1:0]  wr_err_cnt
);

   localparam int LINE_LOG2 = $clog2(LINE_BYTES);
   localparam int NCH       = 2;

   initial begin
      assert ((1 << LINE_LOG2) == LINE_BYTES)
         else $error("LINE_BYTES must be a power of two");
      assert (WIDE_SIZE >= 0 && WIDE_SIZE <= 7)
         else $error("WIDE_SIZE must be a size code 0..7");
      assert (LINE_BYTES >= (1 << WIDE_SIZE))
         else $error("line must hold at least one wide beat");
      assert (ADDR_W >= 8 && ADDR_W >= LINE_LOG2)
         else $error("ADDR_W too narrow");
      assert (CNT_W >= 2 && LEN_W >= 1)
         else $error("CNT_W or LEN_W too small");
   end

   // index 0: read channel, index 1: write channel
   logic [NCH-1:0]             v_a, r_a, lk_a, pv_a;
   logic [NCH-1:0][ADDR_W-1:0] ad_a;
   logic [NCH-1:0][LEN_W-1:0]  ln_a;
   logic [NCH-1:0][2:0]        sz_a;
   logic [NCH-1:0][1:0]        bt_a;
   logic [NCH-1:0][3:0]        ca_a;

   logic [NCH-1:0]             chk_o, err_o, pv_o;
   logic [NCH-1:0][2:0]        code_o;
   logic [NCH-1:0][ADDR_W-1:0] ad_o;
   logic [NCH-1:0][3:0]        ca_o;
   logic [NCH-1:0][CNT_W-1:0]  cc_o, ec_o;

   assign v_a  = {aw_valid, ar_valid};
   assign r_a  = {aw_ready, ar_ready};
   assign lk_a = {aw_lock,  ar_lock};
   assign pv_a = {aw_priv,  ar_priv};
   assign ad_a = {aw_addr,  ar_addr};
   assign ln_a = {aw_len,   ar_len};
   assign sz_a = {aw_size,  ar_size};
   assign bt_a = {aw_burst, ar_burst};
   assign ca_a = {aw_cache, ar_cache};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      axsm_channel #(
         .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES),
         .WIDE_SIZE(WIDE_SIZE), .CNT_W(CNT_W)
      ) u_ch (
         .clk(clk), .rst(rst),
         .valid(v_a[c]), .ready(r_a[c]), .addr(ad_a[c]), .len(ln_a[c]),
         .size(sz_a[c]), .burst(bt_a[c]), .lock(lk_a[c]),
         .cache(ca_a[c]), .priv(pv_a[c]),
         .chk(chk_o[c]), .err(err_o[c]), .code(code_o[c]),
         .o_addr(ad_o[c]), .o_cache(ca_o[c]), .o_priv(pv_o[c]),
         .chk_cnt(cc_o[c]), .err_cnt(ec_o[c])
      );
   end

   assign rd_chk     = chk_o[0];
   assign rd_err     = err_o[0];
   assign rd_code    = code_o[0];
   assign rd_addr    = ad_o[0];
   assign rd_cache   = ca_o[0];
   assign rd_priv    = pv_o[0];
   assign rd_chk_cnt = cc_o[0];
   assign rd_err_cnt = ec_o[0];
   assign wr_chk     = chk_o[1];
   assign wr_err     = err_o[1];
   assign wr_code    = code_o[1];
   assign wr_addr    = ad_o[1];
   assign wr_cache   = ca_o[1];
   assign wr_priv    = pv_o[1];
   assign wr_chk_cnt = cc_o[1];
   assign wr_err_cnt = ec_o[1];

endmodule

// File: tb/axi_subset_monitor_bench.sv
module axi_subset_monitor_bench;

   localparam int AW    = 32;
   localparam int LW    = 4;
   localparam int CW    = 5;
   localparam int CMAX  = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic          ar_valid = 0, ar_ready = 0, ar_lock = 0, ar_priv = 0;
   logic [AW-1:0] ar_addr = '0;
   logic [LW-1:0] ar_len = '0;
   logic [2:0]    ar_size = '0;
   logic [1:0]    ar_burst = 2'b01;
   logic [3:0]    ar_cache = '0;
   logic          aw_valid = 0, aw_ready = 0, aw_lock = 0, aw_priv = 0;
   logic [AW-1:0] aw_addr = '0;
   logic [LW-1:0] aw_len = '0;
   logic [2:0]    aw_size = '0;
   logic [1:0]    aw_burst = 2'b01;
   logic [3:0]    aw_cache = '0;

   logic          rd_chk, rd_err, rd_priv, wr_chk, wr_err, wr_priv;
   logic [2:0]    rd_code, wr_code;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [3:0]    rd_cache, wr_cache;
   logic [CW-1:0] rd_chk_cnt, rd_err_cnt, wr_chk_cnt, wr_err_cnt;

   axi_subset_monitor #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(64),
                        .WIDE_SIZE(4), .CNT_W(CW)) u_axi_subset_monitor (
      .clk(clk), .rst(rst),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
      .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
      .ar_lock(ar_lock), .ar_cache(ar_cache), .ar_priv(ar_priv),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
      .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
      .aw_lock(aw_lock), .aw_cache(aw_cache), .aw_priv(aw_priv),
      .rd_chk(rd_chk), .rd_err(rd_err), .rd_code(rd_code),
      .rd_addr(rd_addr), .rd_cache(rd_cache), .rd_priv(rd_priv),
      .rd_chk_cnt(rd_chk_cnt), .rd_err_cnt(rd_err_cnt),
      .wr_chk(wr_chk), .wr_err(wr_err), .wr_code(wr_code),
      .wr_addr(wr_addr), .wr_cache(wr_cache), .wr_priv(wr_priv),
      .wr_chk_cnt(wr_chk_cnt), .wr_err_cnt(wr_err_cnt)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state, index 0 read, 1 write
   int e_chk[2], e_err[2], e_code[2], e_addr[2], e_cache[2], e_priv[2];
   int e_cc[2], e_ec[2];

   function automatic int ref_code(int burst, int len, int size, int addr,
                                   int lock);
      int beats = len + 1;
      int bytes = beats << size;
      int off   = addr % 64;
      bit shp;
      if (burst == 0) return 1;
      if (burst == 3)      shp = 1;
      else if (burst == 2) shp = !(size == 4 && beats == 4);
      else if (beats == 1) shp = (size > 4);
      else                 shp = !(size == 4 && (beats == 2 || beats == 4));
      if (shp) return 2;
      if (burst == 1 && off + bytes > 64) return 3;
      if (lock != 0 && !(burst == 1 && beats == 1)) return 4;
      if (addr % (1 << size) != 0) return 5;
      return 0;
   endfunction

   task automatic model_ch(int c, bit v, bit r, int addr, int len, int size,
                           int burst, int lock, int cache, int priv);
      int rc;
      if (rst) begin
         e_chk[c] = 0; e_err[c] = 0; e_code[c] = 0; e_addr[c] = 0;
         e_cache[c] = 0; e_priv[c] = 0; e_cc[c] = 0; e_ec[c] = 0;
         return;
      end
      e_chk[c] = (v && r) ? 1 : 0;
      e_err[c] = 0;
      if (v && r) begin
         rc = ref_code(burst, len, size, addr, lock);
         e_code[c] = rc; e_addr[c] = addr; e_cache[c] = cache;
         e_priv[c] = priv;
         if (e_cc[c] < CMAX) e_cc[c]++;
         if (rc != 0) begin
            e_err[c] = 1;
            if (e_ec[c] < CMAX) e_ec[c]++;
         end
      end
   endtask

   task automatic compare(int c, string tag);
      int a_chk, a_err, a_code, a_addr, a_cache, a_priv, a_cc, a_ec;
      if (c == 0) begin
         a_chk = rd_chk; a_err = rd_err; a_code = rd_code; a_addr = rd_addr;
         a_cache = rd_cache; a_priv = rd_priv; a_cc = rd_chk_cnt;
         a_ec = rd_err_cnt;
      end else begin
         a_chk = wr_chk; a_err = wr_err; a_code = wr_code; a_addr = wr_addr;
         a_cache = wr_cache; a_priv = wr_priv; a_cc = wr_chk_cnt;
         a_ec = wr_err_cnt;
      end
      total++;
      if (a_chk != e_chk[c] || a_err != e_err[c] || a_code != e_code[c] ||
          a_addr != e_addr[c] || a_cache != e_cache[c] ||
          a_priv != e_priv[c] || a_cc != e_cc[c] || a_ec != e_ec[c]) begin
         bad++;
         $display("FAIL %s ch%0d actual chk=%0d err=%0d code=%0d addr=%0h cache=%0h priv=%0d cc=%0d ec=%0d expected chk=%0d err=%0d code=%0d addr=%0h cache=%0h priv=%0d cc=%0d ec=%0d",
                  tag, c, a_chk, a_err, a_code, a_addr, a_cache, a_priv,
                  a_cc, a_ec, e_chk[c], e_err[c], e_code[c], e_addr[c],
                  e_cache[c], e_priv[c], e_cc[c], e_ec[c]);
      end
   endtask

   // advance one clock, update model with the inputs that were sampled
   task automatic tick(string tag);
      @(negedge clk);
      model_ch(0, ar_valid, ar_ready, int'(ar_addr), int'(ar_len),
               int'(ar_size), int'(ar_burst), int'(ar_lock),
               int'(ar_cache), int'(ar_priv));
      model_ch(1, aw_valid, aw_ready, int'(aw_addr), int'(aw_len),
               int'(aw_size), int'(aw_burst), int'(aw_lock),
               int'(aw_cache), int'(aw_priv));
      compare(0, tag);
      compare(1, tag);
   endtask

   task automatic rd(bit v, bit r, int addr, int len, int size, int burst,
                     bit lock, int cache, bit priv);
      ar_valid = v; ar_ready = r; ar_addr = AW'(addr); ar_len = LW'(len);
      ar_size = 3'(size); ar_burst = 2'(burst); ar_lock = lock;
      ar_cache = 4'(cache); ar_priv = priv;
   endtask

   task automatic wr(bit v, bit r, int addr, int len, int size, int burst,
                     bit lock, int cache, bit priv);
      aw_valid = v; aw_ready = r; aw_addr = AW'(addr); aw_len = LW'(len);
      aw_size = 3'(size); aw_burst = 2'(burst); aw_lock = lock;
      aw_cache = 4'(cache); aw_priv = priv;
   endtask

   task automatic idle();
      ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;
   endtask

   initial begin
      rst = 1; idle();
      tick("R11 reset"); tick("R11 reset");
      rst = 0;
      tick("R11 after reset");

      // R1: valid without ready, ready without valid
      rd(1, 0, 'h40, 0, 2, 0, 0, 0, 0); wr(0, 1, 'h40, 0, 2, 0, 0, 0, 0);
      tick("R1 no handshake");
      idle(); tick("R1 idle");

      // R3 wrapping fills
      rd(1, 1, 'h1030, 3, 4, 2, 0, 'hf, 0); tick("R3 wrap critical word");
      rd(1, 1, 'h1000, 3, 4, 2, 0, 'h3, 1); tick("R3 wrap line start");
      rd(1, 1, 'h1000, 1, 4, 2, 0, 0, 0);   tick("R3 wrap 2 beats");
      rd(1, 1, 'h1000, 3, 3, 2, 0, 0, 0);   tick("R3 wrap 8-byte beat");
      rd(1, 1, 'h1008, 3, 4, 2, 0, 0, 0);   tick("R7 wrap misaligned");

      // R2 fixed and reserved
      wr(1, 1, 'h200, 0, 2, 0, 0, 0, 0);    tick("R2 fixed write");
      rd(1, 1, 'h200, 3, 4, 0, 0, 0, 0);    tick("R2 fixed read");
      rd(1, 1, 'h200, 0, 2, 3, 0, 0, 0);    tick("R2 reserved burst");
      rd(1, 1, 'h203, 2, 7, 0, 1, 0, 0);    tick("R8 fixed beats all");
      idle(); tick("R1 idle");

      // R4 incrementing shapes
      for (int s = 0; s < 8; s++) begin
         wr(1, 1, 'h300, 0, s, 1, 0, s, 0); tick("R4 single size");
      end
      wr(1, 1, 'h320, 1, 4, 1, 0, 0, 0);    tick("R4 incr 2 wide");
      wr(1, 1, 'h300, 3, 4, 1, 0, 0, 0);    tick("R4 incr 4 wide");
      wr(1, 1, 'h300, 2, 4, 1, 0, 0, 0);    tick("R4 incr 3 beats");
      wr(1, 1, 'h300, 1, 3, 1, 0, 0, 0);    tick("R4 incr narrow multi");
      wr(1, 1, 'h300, 7, 4, 1, 0, 0, 0);    tick("R4 incr 8 beats");

      // R5 line crossing
      wr(1, 1, 'h310, 3, 4, 1, 0, 0, 0);    tick("R5 incr4 crosses");
      wr(1, 1, 'h330, 1, 4, 1, 0, 0, 0);    tick("R5 incr2 crosses");
      wr(1, 1, 'h320, 1, 4, 1, 0, 0, 0);    tick("R5 incr2 fits exactly");
      wr(1, 1, 'h33f, 0, 4, 1, 0, 0, 0);    tick("R8 cross before align");
      idle(); tick("R1 idle");

      // R6 exclusive
      rd(1, 1, 'h404, 0, 2, 1, 1, 0, 0);    tick("R6 excl single ok");
      rd(1, 1, 'h400, 1, 4, 1, 1, 0, 0);    tick("R6 excl burst");
      rd(1, 1, 'h400, 3, 4, 2, 1, 0, 0);    tick("R6 excl wrap");
      rd(1, 1, 'h402, 0, 2, 1, 1, 0, 0);    tick("R7 excl misaligned");
      rd(1, 1, 'h408, 1, 4, 1, 1, 0, 0);    tick("R8 excl before align");

      // R7 alignment
      rd(1, 1, 'h501, 0, 1, 1, 0, 0, 0);    tick("R7 halfword odd");
      rd(1, 1, 'h504, 0, 3, 1, 0, 0, 0);    tick("R7 dword at 4");
      rd(1, 1, 'h507, 0, 0, 1, 0, 0, 0);    tick("R7 byte any addr");

      // R9 priv and cache do not change verdict
      wr(1, 1, 'h600, 0, 3, 1, 0, 'h0, 0);  tick("R9 priv low");
      wr(1, 1, 'h600, 0, 3, 1, 0, 'hb, 1);  tick("R9 priv high");
      wr(1, 1, 'h610, 3, 4, 1, 0, 'h7, 1);  tick("R9 violation priv");
      idle(); tick("R1 idle");

      // R12 both channels in the same cycle, back to back
      rd(1, 1, 'h700, 0, 2, 0, 0, 'h1, 1);
      wr(1, 1, 'h730, 1, 4, 1, 0, 'h2, 0);  tick("R12 same cycle");
      rd(1, 1, 'h740, 3, 4, 2, 0, 'h3, 0);
      wr(1, 1, 'h742, 0, 2, 1, 0, 'h4, 1);  tick("R12 same cycle");
      rd(1, 1, 'h780, 1, 4, 1, 1, 'h5, 1);
      wr(1, 1, 'h780, 0, 4, 1, 1, 'h6, 0);  tick("R12 same cycle");
      idle(); tick("R1 idle"); tick("R1 idle");

      // R11 mid-run reset
      rst = 1; tick("R11 mid reset");
      rst = 0; tick("R11 cleared");

      // R10 saturation on read, write stays legal-counting
      for (int i = 0; i < CMAX + 6; i++) begin
         rd(1, 1, 'h800 + (i % 4), 0, 1, 1, 0, 0, 0);
         wr(1, 1, 'h900, 0, 2, 1, 0, 0, 0);
         tick("R10 saturate");
      end
      idle(); tick("R10 held"); tick("R10 held");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule